// File: doc/BRIEF.md
# Word-Serial Montgomery Multiplier

This block forms the Montgomery product A·B·2^(-32n) mod M for operands of n 32-bit words, with n chosen per operation between 8 and a parameterised maximum (64 words, 2048 bits, by default) in steps of 4 words. The operands sit in internal word register files that a host fills through a narrow load port. A single pipelined 32x32 multiplier is shared by every product the algorithm needs. A running partial-sum array is accumulated row by row, and a 33-bit carry links the words within a row.

For each word B[i], the block first derives a quotient digit u = (T[0] + A[0]·B[i])·m' mod 2^32. Here m' = −M⁻¹ mod 2^32 is supplied by the host. The block then sweeps j across A, M and T. Each step adds T[j] + A[j]·B[i] + M[j]·u + carry, and the low word lands in T[j−1], which performs the word shift. Once every row is done, the block subtracts M word by word into a second array. If the partial sum is at least M, the result port then shows the difference, so the result is always below M. Conversion into and out of Montgomery form, and exponentiation sequencing, are left to the host.

Top module: `montmul_ws`

## Requirements
- R1: A start with a length that is not a multiple of 4 words, below 8 words or above the maximum raises err on the next cycle. busy stays low, no done follows, and the previously produced result words read back unchanged.
- R2: Out of reset busy, done and err are low. A start with a valid length while idle raises busy on the next cycle and clears err.
- R3: For odd M and A, B below M, the result equals A·B·2^(-32n) mod M and is fully reduced below M. This holds whether or not the final subtraction is needed.
- R4: done is a single-cycle pulse marking the end of an operation, and busy is low in the cycle that done is high.
- R5: A start pulse while busy has no effect: the running operation completes with its own length, and exactly one done pulse appears.
- R6: After done, result word k (word 0 least significant) is presented combinationally on rd_data for rd_addr = k, and it stays readable until the next accepted start.
- R7: Load writes go to A when ld_sel = 0, to B when ld_sel = 1 and to M when ld_sel = 2, with word 0 the least significant. Load writes while busy are ignored.
- R8: The minimum length of 8 words and the maximum length of 64 words both produce correct results.
- R9: An all-zero A operand yields an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write one operand word |
| ld_sel | input | 2 | Target array: 0 A, 1 B, 2 M |
| ld_addr | input | 6 | Word index of the load |
| ld_data | input | 32 | Word value to load |
| mprime | input | 32 | −M⁻¹ mod 2^32, sampled at start |
| len_words | input | 7 | Operand length in 32-bit words, sampled at start |
| start | input | 1 | Begin an operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start carried an unsupported length |
| rd_addr | input | 6 | Result word index |
| rd_data | output | 32 | Result word at rd_addr |

## Verification
busy and err are registered from the start pulse, so the bench checks them exactly one cycle after the edge at which start was sampled. done has no fixed latency, because it grows with n², so the bench watches for it on every falling edge with a bounded wait. The bench then checks that it is gone one cycle later. Result words come from a combinational read port and are compared after rd_addr settles, mid-cycle. For rejected lengths, the bench waits a fixed stretch of cycles to confirm that done stays quiet and the old result is intact.

// File: rtl/mm_pkg.sv
package mm_pkg;

  localparam int WORD_W    = 32;
  localparam int MIN_WORDS = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_CLR, S_ISSUE, S_WAIT, S_TOP, S_SUB, S_FIN
  } mm_state_e;

  typedef enum logic [1:0] {
    PH_U1, PH_U2, PH_AB, PH_MU
  } mm_phase_e;

  // One column step: t + p_ab + p_mu + carry, never above 65 bits.
  function automatic logic [64:0] col_sum(input logic [31:0] t,
                                          input logic [63:0] p_ab,
                                          input logic [63:0] p_mu,
                                          input logic [32:0] cin);
    return 65'(t) + 65'(p_ab) + 65'(p_mu) + 65'(cin);
  endfunction

  // Supported lengths: multiples of 4 words, from 8 up to maxw.
  function automatic logic length_ok(input logic [15:0] len,
                                     input int unsigned maxw);
    return (len >= 16'(MIN_WORDS)) && (32'(len) <= maxw) && (len[1:0] == 2'b00);
  endfunction

  // Borrowing subtract of one word pair.
  function automatic logic [32:0] word_sub(input logic [31:0] x,
                                           input logic [31:0] y,
                                           input logic bin);
    return {1'b0, x} - {1'b0, y} - 33'(bin);
  endfunction

endpackage

// File: rtl/mm_regfile.sv
module mm_regfile #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  parameter int NR    = 1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [W-1:0]         wdata,
  input  logic [NR-1:0][AW-1:0] raddr,
  output logic [NR-1:0][W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar r = 0; r < NR; r++) begin : g_rd
    assign rdata[r] = mem[raddr[r]];
  end

endmodule

// File: rtl/mm_mul32.sv
module mm_mul32 #(
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [31:0] x,
  input  logic [31:0] y,
  output logic        vld,
  output logic [63:0] p
);

  logic [31:0]       xr, yr;
  logic [STAGES-1:0] vv;
  logic [63:0]       pp [1:STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vv <= '0;
    else        vv <= {vv[STAGES-2:0], go};
  end

  always_ff @(posedge clk) begin
    if (go) begin
      xr <= x;
      yr <= y;
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_pipe
    if (s == 1) begin : g_first
      always_ff @(posedge clk) pp[s] <= 64'(xr) * 64'(yr);
    end else begin : g_next
      always_ff @(posedge clk) pp[s] <= pp[s-1];
    end
  end

  assign vld = vv[STAGES-1];
  assign p   = pp[STAGES-1];

endmodule

// File: rtl/montmul_ws.sv
module montmul_ws
  import mm_pkg::*;
#(
  parameter int MAX_WORDS  = 64,
  parameter int MUL_STAGES = 2,
  localparam int ADDR_W    = $clog2(MAX_WORDS),
  localparam int LEN_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [1:0]        ld_sel,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [31:0]       ld_data,
  input  logic [31:0]       mprime,
  input  logic [LEN_W-1:0]  len_words,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data
);

  mm_state_e        state;
  mm_phase_e        phase;
  logic [LEN_W-1:0] i_q, j_q, n_q;
  logic [31:0]      mp_q, u_q, uacc_q;
  logic [63:0]      p1_q;
  logic [32:0]      carry_q;
  logic [1:0]       ttop_q;
  logic             borrow_q, use_diff_q;

  // Named internal events for the checker.
  logic start_ok, start_bad, wait_st;
  logic [LEN_W-1:0] j_m1, n_m1;
  logic last_j, last_i;

  assign start_ok  = start && !busy &&  length_ok(16'(len_words), MAX_WORDS);
  assign start_bad = start && !busy && !length_ok(16'(len_words), MAX_WORDS);
  assign wait_st   = (state == S_WAIT);
  assign j_m1      = j_q - 1'b1;
  assign n_m1      = n_q - 1'b1;
  assign last_j    = (j_q == n_m1);
  assign last_i    = (i_q == n_m1);

  // Operand stores
  logic                       host_we;
  logic [0:0][ADDR_W-1:0]     a_ra, b_ra, m_ra, r_ra;
  logic [0:0][31:0]           a_rd, b_rd, m_rd, r_rd;
  logic [1:0][ADDR_W-1:0]     t_ra;
  logic [1:0][31:0]           t_rd;

  assign host_we = ld_en && !busy;
  assign a_ra[0] = j_q[ADDR_W-1:0];
  assign m_ra[0] = j_q[ADDR_W-1:0];
  assign b_ra[0] = i_q[ADDR_W-1:0];
  assign t_ra[0] = j_q[ADDR_W-1:0];
  assign t_ra[1] = rd_addr;
  assign r_ra[0] = rd_addr;

  mm_regfile #(.DEPTH(MAX_WORDS), .W(32), .NR(1)) u_a (
    .clk(clk), .we(host_we && ld_sel == 2'd0), .waddr(ld_addr), .wdata(ld_data),
    .raddr(a_ra), .rdata(a_rd));
  mm_regfile #(.DEPTH(MAX_WORDS), .W(32), .NR(1)) u_b (
    .clk(clk), .we(host_we && ld_sel == 2'd1), .waddr(ld_addr), .wdata(ld_data),
    .raddr(b_ra), .rdata(b_rd));
  mm_regfile #(.DEPTH(MAX_WORDS), .W(32), .NR(1)) u_m (
    .clk(clk), .we(host_we && ld_sel == 2'd2), .waddr(ld_addr), .wdata(ld_data),
    .raddr(m_ra), .rdata(m_rd));

  // Partial-sum array and difference array
  logic              t_we, r_we;
  logic [ADDR_W-1:0] t_waddr;
  logic [31:0]       t_wdata;
  logic [32:0]       diff;

  mm_regfile #(.DEPTH(MAX_WORDS), .W(32), .NR(2)) u_t (
    .clk(clk), .we(t_we), .waddr(t_waddr), .wdata(t_wdata),
    .raddr(t_ra), .rdata(t_rd));
  mm_regfile #(.DEPTH(MAX_WORDS), .W(32), .NR(1)) u_r (
    .clk(clk), .we(r_we), .waddr(j_q[ADDR_W-1:0]), .wdata(diff[31:0]),
    .raddr(r_ra), .rdata(r_rd));

  // Shared multiplier
  logic        mul_go, mul_vld;
  logic [31:0] mul_x, mul_y;
  logic [63:0] mul_p;

  assign mul_go = (state == S_ISSUE);

  always_comb begin
    unique case (phase)
      PH_U1:   begin mul_x = a_rd[0]; mul_y = b_rd[0]; end
      PH_U2:   begin mul_x = uacc_q;  mul_y = mp_q;    end
      PH_AB:   begin mul_x = a_rd[0]; mul_y = b_rd[0]; end
      default: begin mul_x = m_rd[0]; mul_y = u_q;     end
    endcase
  end

  mm_mul32 #(.STAGES(MUL_STAGES)) u_mul (
    .clk(clk), .rst_n(rst_n), .go(mul_go), .x(mul_x), .y(mul_y),
    .vld(mul_vld), .p(mul_p));

  // Datapath sums
  logic [64:0] acc;
  logic [33:0] top_sum;
  logic        col_done;

  assign acc      = col_sum(t_rd[0], p1_q, mul_p, carry_q);
  assign top_sum  = 34'(ttop_q) + 34'(carry_q);
  assign diff     = word_sub(t_rd[0], m_rd[0], borrow_q);
  assign col_done = wait_st && mul_vld && (phase == PH_MU);

  always_comb begin
    t_we    = 1'b0;
    t_waddr = j_q[ADDR_W-1:0];
    t_wdata = '0;
    if (state == S_CLR) begin
      t_we = 1'b1;
    end else if (col_done && j_q != '0) begin
      t_we    = 1'b1;
      t_waddr = j_m1[ADDR_W-1:0];
      t_wdata = acc[31:0];
    end else if (state == S_TOP) begin
      t_we    = 1'b1;
      t_waddr = n_m1[ADDR_W-1:0];
      t_wdata = top_sum[31:0];
    end
  end

  assign r_we    = (state == S_SUB);
  assign rd_data = use_diff_q ? r_rd[0] : t_rd[1];

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      phase      <= PH_U1;
      i_q        <= '0;
      j_q        <= '0;
      n_q        <= '0;
      mp_q       <= '0;
      u_q        <= '0;
      uacc_q     <= '0;
      p1_q       <= '0;
      carry_q    <= '0;
      ttop_q     <= '0;
      borrow_q   <= 1'b0;
      use_diff_q <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start_ok) begin
            n_q   <= len_words;
            mp_q  <= mprime;
            busy  <= 1'b1;
            err   <= 1'b0;
            j_q   <= '0;
            state <= S_CLR;
          end else if (start_bad) begin
            err <= 1'b1;
          end
        end
        S_CLR: begin
          if (last_j) begin
            ttop_q <= '0;
            i_q    <= '0;
            j_q    <= '0;
            phase  <= PH_U1;
            state  <= S_ISSUE;
          end else begin
            j_q <= j_q + 1'b1;
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: begin
          if (mul_vld) begin
            state <= S_ISSUE;
            unique case (phase)
              PH_U1: begin
                uacc_q <= t_rd[0] + mul_p[31:0];
                phase  <= PH_U2;
              end
              PH_U2: begin
                u_q     <= mul_p[31:0];
                carry_q <= '0;
                phase   <= PH_AB;
              end
              PH_AB: begin
                p1_q  <= mul_p;
                phase <= PH_MU;
              end
              default: begin
                carry_q <= acc[64:32];
                phase   <= PH_AB;
                if (last_j) state <= S_TOP;
                else        j_q   <= j_q + 1'b1;
              end
            endcase
          end
        end
        S_TOP: begin
          ttop_q <= top_sum[33:32];
          j_q    <= '0;
          if (last_i) begin
            borrow_q <= 1'b0;
            state    <= S_SUB;
          end else begin
            i_q   <= i_q + 1'b1;
            phase <= PH_U1;
            state <= S_ISSUE;
          end
        end
        S_SUB: begin
          borrow_q <= diff[32];
          if (last_j) state <= S_FIN;
          else        j_q   <= j_q + 1'b1;
        end
        default: begin
          use_diff_q <= (ttop_q != 2'b00) || !borrow_q;
          busy       <= 1'b0;
          done       <= 1'b1;
          state      <= S_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/mm_checker.sv
module mm_checker #(
  parameter int LEN_W  = 7,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              start_ok,
  input logic              start_bad,
  input logic              mul_vld,
  input logic              wait_st,
  input logic              t_we,
  input logic [ADDR_W-1:0] t_waddr,
  input logic [LEN_W-1:0]  n_q
);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (busy && !err));

  // R1
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> (err && !busy));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(n_q));

  // R3
  mul_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_vld |-> wait_st);

  // R3
  t_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_we |-> (LEN_W'(t_waddr) < n_q));

endmodule

bind montmul_ws mm_checker #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
  .start_ok(start_ok), .start_bad(start_bad), .mul_vld(mul_vld),
  .wait_st(wait_st), .t_we(t_we), .t_waddr(t_waddr), .n_q(n_q));

// File: tb/tb_montmul_ws.sv
`timescale 1ns/1ps
module tb_montmul_ws;

  localparam int MAXW = 64;
  localparam int BW   = 32 * MAXW + 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] mprime = '0;
  logic [6:0]  len_words = '0;
  logic        start = 1'b0;
  logic        busy, done, err;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;

  always #10 clk = ~clk;

  montmul_ws dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .mprime(mprime), .len_words(len_words), .start(start),
    .busy(busy), .done(done), .err(err), .rd_addr(rd_addr), .rd_data(rd_data));

  int vecs = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] av [MAXW];
  logic [31:0] bv [MAXW];
  logic [31:0] mv [MAXW];
  logic [31:0] ev [MAXW];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  // Operand generation: M odd with top bit set, A and B below M.
  task automatic gen_ops(input int n);
    for (int k = 0; k < n; k++) begin
      av[k] = $urandom;
      bv[k] = $urandom;
      mv[k] = $urandom;
    end
    mv[0]   = mv[0] | 32'h1;
    mv[n-1] = mv[n-1] | 32'h8000_0000;
    av[n-1] = av[n-1] & 32'h7fff_ffff;
    bv[n-1] = bv[n-1] & 32'h7fff_ffff;
  endtask

  // Bit-serial model: T = (T + a_k*B + q*M)/2 over 32n bits, then reduce.
  task automatic model(input int n);
    logic [BW-1:0] ra, rb, rm, rt;
    ra = '0; rb = '0; rm = '0; rt = '0;
    for (int k = 0; k < n; k++) begin
      ra[32*k +: 32] = av[k];
      rb[32*k +: 32] = bv[k];
      rm[32*k +: 32] = mv[k];
    end
    for (int k = 0; k < 32 * n; k++) begin
      if (ra[k]) rt = rt + rb;
      if (rt[0]) rt = rt + rm;
      rt = rt >> 1;
    end
    if (rt >= rm) rt = rt - rm;
    for (int k = 0; k < n; k++) ev[k] = rt[32*k +: 32];
  endtask

  function automatic logic [31:0] neg_inv(input logic [31:0] m0);
    logic [31:0] inv;
    inv = 32'h1;
    for (int k = 0; k < 5; k++) inv = inv * (32'h2 - m0 * inv);
    return -inv;
  endfunction

  task automatic load_word(input logic [1:0] sel, input int k, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_addr = 6'(k); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic load_all(input int n);
    for (int k = 0; k < n; k++) begin
      load_word(2'd0, k, av[k]);
      load_word(2'd1, k, bv[k]);
      load_word(2'd2, k, mv[k]);
    end
    mprime = neg_inv(mv[0]);
  endtask

  // Pulse start; optionally pulse it again while busy with other length.
  task automatic run_op(input string req, input int n, input bit poke);
    int cnt;
    int ndone;
    @(negedge clk);
    len_words = 7'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy after start", 32'(busy), 32'd1);
    chk("R2", "err after start", 32'(err), 32'd0);
    if (poke) begin
      repeat (5) @(negedge clk);
      len_words = 7'd12; start = 1'b1;
      ld_en = 1'b1; ld_sel = 2'd0; ld_addr = 6'd0; ld_data = 32'hdead_beef;
      @(negedge clk);
      start = 1'b0; ld_en = 1'b0;
    end
    cnt = 0; ndone = 0;
    while (ndone == 0 && cnt < 100000) begin
      @(negedge clk);
      cnt++;
      if (done) ndone++;
    end
    chk(req, "done seen", 32'(ndone), 32'd1);
    chk("R4", "busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R4", "done one cycle", 32'(done), 32'd0);
    if (poke) begin
      cnt = 0;
      repeat (200) begin
        @(negedge clk);
        if (done) cnt++;
      end
      chk("R5", "extra done pulses", 32'(cnt), 32'd0);
    end
  endtask

  task automatic check_result(input string req, input int n);
    int bad;
    logic [31:0] first_a, first_e;
    bad = 0; first_a = '0; first_e = '0;
    for (int k = n - 1; k >= 0; k--) begin
      rd_addr = 6'(k);
      #1;
      if (rd_data !== ev[k]) begin
        if (bad == 0) begin first_a = rd_data; first_e = ev[k]; end
        bad++;
      end
    end
    chk(req, "result words", first_a, first_e);
  endtask

  task automatic t_reset();
    chk("R2", "reset busy", 32'(busy), 32'd0);
    chk("R2", "reset done", 32'(done), 32'd0);
    chk("R2", "reset err", 32'(err), 32'd0);
  endtask

  task automatic t_random(input string req, input int n);
    gen_ops(n);
    load_all(n);
    model(n);
    run_op(req, n, 1'b0);
    check_result(req, n);
  endtask

  task automatic t_near_m();
    // A = B = M-1 exercises large partial sums and the final subtract path.
    gen_ops(8);
    for (int k = 0; k < 8; k++) begin av[k] = mv[k]; bv[k] = mv[k]; end
    av[0] = mv[0] - 32'h1;
    bv[0] = mv[0] - 32'h1;
    load_all(8);
    model(8);
    run_op("R3", 8, 1'b0);
    check_result("R3", 8);
  endtask

  task automatic t_zero();
    gen_ops(12);
    for (int k = 0; k < 12; k++) av[k] = '0;
    load_all(12);
    model(12);
    run_op("R9", 12, 1'b0);
    check_result("R9", 12);
    rd_addr = 6'd5; #1;
    chk("R9", "zero word 5", rd_data, 32'h0);
  endtask

  task automatic t_ignore_busy();
    gen_ops(8);
    load_all(8);
    model(8);
    run_op("R5", 8, 1'b1);
    // R7: the write to A word 0 while busy must not have landed.
    check_result("R7", 8);
    // R6: readback repeated later still gives the same words.
    repeat (30) @(negedge clk);
    check_result("R6", 8);
  endtask

  task automatic t_bad_len();
    int lens [4] = '{10, 4, 68, 0};
    gen_ops(8);
    load_all(8);
    model(8);
    run_op("R3", 8, 1'b0);
    for (int q = 0; q < 4; q++) begin
      int cnt;
      @(negedge clk);
      len_words = 7'(lens[q]); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R1", "err raised", 32'(err), 32'd1);
      chk("R1", "busy stays low", 32'(busy), 32'd0);
      cnt = 0;
      repeat (60) begin
        @(negedge clk);
        if (done || busy) cnt++;
      end
      chk("R1", "no activity", 32'(cnt), 32'd0);
      check_result("R1", 8);
    end
    // A following valid start clears err (checked inside run_op).
    gen_ops(8);
    load_all(8);
    model(8);
    run_op("R2", 8, 1'b0);
    check_result("R3", 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_random("R8", 8);
    t_random("R3", 16);
    t_near_m();
    t_zero();
    t_ignore_busy();
    t_bad_len();
    t_random("R8", 64);
    summary();
  end

endmodule